// File: doc/BRIEF.md
# Shared interrupt source conditioner

This block takes a set of external shared interrupt lines, conditions each one according to its own sensing mode, and turns it into a pending bit. Each line can be level sensed (active-high or active-low), sensed on a single edge (rising or falling), or sensed on both edges. Edge-sensed lines latch their pending bit until software clears it through a software edge register. The same register lets software raise an edge on any edge-sensed line.

A per-line enable mask is changed only through a write-one-to-set bank and a write-one-to-clear bank, and it can be read back. Every pending line whose mask bit is set is routed by its own map register to one CPU interrupt pin, to the non-maskable interrupt output, or to both. All configuration and status is reached through a plain 32-bit register read/write port. Raw inputs are synchronised by two flops before they are sensed.

Top module: `shared_irq_cond`

## Requirements
- R1: After reset every mask bit, pending bit, trigger bit, dual bit and map register reads as zero, every polarity bit reads as one, and the pin and NMI outputs are low.
- R2: A line whose trigger bit is 0 is level sensed. Its pending bit is the synchronised input when its polarity bit is 1 and the inverted input when it is 0. A change at the input shows in the pending bit 3 clock edges later.
- R3: A line whose trigger bit is 1 and dual bit is 0 sets its pending bit on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. The bit then stays set when the input changes again.
- R4: A line whose trigger bit is 1 and dual bit is 1 sets its pending bit on either edge, whatever its polarity bit.
- R5: A write to offset 0x280 addresses the line in bits 7:0. Bit 31 = 1 sets that line's pending bit and bit 31 = 0 clears it. The write is ignored for level-sensed lines and for line numbers at or above the line count.
- R6: A write to the mask-set bank at 0x380 sets the mask bits written as 1. A write to the mask-clear bank at 0x300 clears the mask bits written as 1. Bits written as 0 leave the mask unchanged. The mask reads back at 0x400.
- R7: Polarity (0x100), trigger (0x180), dual (0x200), mask (0x400) and pending (0x480) are banks of 32-bit words. Line n is bit n%32 of the word at bank base + 4*(n/32).
- R8: Line n has a map register at 0x500 + 4*n. Bit 31 routes it to a CPU pin, bit 30 routes it to NMI, and bits 5:0 hold the pin number. It reads back with all other bits zero.
- R9: CPU pin p is high while any line is pending, unmasked, routed to a pin and has pin number p. A pin number at or above the pin count drives no pin.
- R10: The NMI output is high while any pending, unmasked line has its NMI route bit set.
- R11: A read strobe loads the addressed register into the read data output at the next clock edge. Without a strobe the output holds. Addresses that name no register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_pin | output | NUM_PINS | CPU interrupt pin outputs |
| irq_nmi | output | 1 | Non-maskable interrupt output |

NUM_LINES must be a multiple of 32 and no more than 256. NUM_PINS is at most 64.

## Verification
Assertions check several rules on every cycle. An edge-sensed pending bit holds until a software clear. A qualifying edge on a dual-edge line always latches. A software clear with no coincident edge empties the bit. An inactive level line is never pending. The mask and map writes land as written, the read data holds without a strobe, and a fully cleared mask silences every output. Only the bench's scenarios can show the full chain from a raw input through synchronisation, mode selection, masking and pin-number routing. The same holds for the rules about ignored writes: zero mask bits, software edges aimed at level lines or absent lines, and out-of-range pin numbers.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int ADDR_W = 12;
    localparam int REG_W  = 32;
    localparam int PIN_W  = 6;

    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_DUAL   = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_SWEDGE = 12'h280;
    localparam logic [ADDR_W-1:0] OFS_MCLR   = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_MSET   = 12'h380;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 12'h480;
    localparam logic [ADDR_W-1:0] OFS_MAP    = 12'h500;

    typedef enum logic [3:0] {
        RG_NONE, RG_POL, RG_TRIG, RG_DUAL, RG_SWEDGE,
        RG_MCLR, RG_MSET, RG_MASK, RG_PEND, RG_MAP
    } reg_sel_e;

    typedef struct packed {
        logic             to_pin;
        logic             to_nmi;
        logic [PIN_W-1:0] pin;
    } route_t;

    typedef struct packed {
        logic level_hi;
        logic edge_mode;
        logic both_edges;
    } line_cfg_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a >= OFS_MAP) begin
                s = RG_MAP;
            end else begin
                case (a[ADDR_W-1:7])
                    5'd2: s = RG_POL;
                    5'd3: s = RG_TRIG;
                    5'd4: s = RG_DUAL;
                    5'd5: s = (a[6:2] == 5'd0) ? RG_SWEDGE : RG_NONE;
                    5'd6: s = RG_MCLR;
                    5'd7: s = RG_MSET;
                    5'd8: s = RG_MASK;
                    5'd9: s = RG_PEND;
                    default: s = RG_NONE;
                endcase
            end
        end
        return s;
    endfunction

    function automatic logic [REG_W-1:0] route_word(input route_t r);
        return {r.to_pin, r.to_nmi, {(REG_W-2-PIN_W){1'b0}}, r.pin};
    endfunction

endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] smp_o
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign smp_o = stage2_q;
endmodule

// File: rtl/sic_line.sv
module sic_line
    import sic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_i,
    input  line_cfg_t cfg_i,
    input  logic      sw_set_i,
    input  logic      sw_clr_i,
    output logic      pend_o
);
    logic prev_q, pend_q;
    logic rise, fall, hit, active;

    assign rise   = smp_i & ~prev_q;
    assign fall   = ~smp_i & prev_q;
    assign active = cfg_i.level_hi ? smp_i : ~smp_i;

    always_comb begin
        if (cfg_i.both_edges) hit = rise | fall;
        else                  hit = cfg_i.level_hi ? rise : fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= smp_i;
            if (!cfg_i.edge_mode)      pend_q <= active;
            else if (hit || sw_set_i)  pend_q <= 1'b1;
            else if (sw_clr_i)         pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R3
    sticky_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && pend_q && !sw_clr_i) |=> pend_q);

    // R4
    dual_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && cfg_i.both_edges && (smp_i != prev_q)) |=> pend_q);

    // R5
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_mode && sw_clr_i && !sw_set_i && (smp_i == prev_q)) |=> !pend_q);

    // R2
    level_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.edge_mode && (smp_i != cfg_i.level_hi)) |=> !pend_q);
endmodule

// File: rtl/sic_router.sv
module sic_router
    import sic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_PINS  = 8
) (
    input  logic [NUM_LINES-1:0] act_i,
    input  route_t               route_i [NUM_LINES],
    output logic [NUM_PINS-1:0]  pin_o,
    output logic                 nmi_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int n = 0; n < NUM_LINES; n++) begin
                if (act_i[n] && route_i[n].to_pin && (route_i[n].pin == PIN_W'(p)))
                    acc = 1'b1;
            end
        end
        assign pin_o[p] = acc;
    end

    always_comb begin
        nmi_o = 1'b0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (act_i[n] && route_i[n].to_nmi) nmi_o = 1'b1;
        end
    end
endmodule

// File: rtl/shared_irq_cond.sv
module shared_irq_cond
    import sic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_PINS  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_PINS-1:0]  irq_pin,
    output logic                 irq_nmi
);
    localparam int NWORDS = NUM_LINES / REG_W;
    localparam int MIDX_W = ADDR_W - 2;

    logic [NUM_LINES-1:0] pol_q, trig_q, dual_q, mask_q;
    route_t               route_q [NUM_LINES];
    logic [NUM_LINES-1:0] smp, pend, act, sw_set, sw_clr;
    line_cfg_t            cfg [NUM_LINES];
    logic [REG_W-1:0]     rd_word, rdata_q;

    reg_sel_e          sel;
    logic [4:0]        wsel;
    logic [MIDX_W-1:0] midx;

    assign sel  = decode_sel(reg_addr);
    assign wsel = reg_addr[6:2];
    assign midx = MIDX_W'((reg_addr - OFS_MAP) >> 2);

    function automatic logic [REG_W-1:0] pick_word(input logic [NUM_LINES-1:0] v,
                                                   input logic [4:0] ws);
        logic [REG_W-1:0] r;
        r = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (ws == 5'(w)) r = v[w*REG_W +: REG_W];
        end
        return r;
    endfunction

    // configuration, mask and route storage
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '1;
            trig_q <= '0;
            dual_q <= '0;
            mask_q <= '0;
            for (int n = 0; n < NUM_LINES; n++) route_q[n] <= '0;
        end else if (reg_we) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (wsel == 5'(w)) begin
                    case (sel)
                        RG_POL:  pol_q[w*REG_W +: REG_W]  <= reg_wdata;
                        RG_TRIG: trig_q[w*REG_W +: REG_W] <= reg_wdata;
                        RG_DUAL: dual_q[w*REG_W +: REG_W] <= reg_wdata;
                        RG_MSET: mask_q[w*REG_W +: REG_W] <= mask_q[w*REG_W +: REG_W] | reg_wdata;
                        RG_MCLR: mask_q[w*REG_W +: REG_W] <= mask_q[w*REG_W +: REG_W] & ~reg_wdata;
                        default: ;
                    endcase
                end
            end
            for (int n = 0; n < NUM_LINES; n++) begin
                if (sel == RG_MAP && midx == MIDX_W'(n))
                    route_q[n] <= '{to_pin: reg_wdata[31], to_nmi: reg_wdata[30],
                                    pin: reg_wdata[PIN_W-1:0]};
            end
        end
    end

    // software edge decode
    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            sw_set[n] = reg_we && (sel == RG_SWEDGE) && (reg_wdata[7:0] == 8'(n)) && reg_wdata[31];
            sw_clr[n] = reg_we && (sel == RG_SWEDGE) && (reg_wdata[7:0] == 8'(n)) && !reg_wdata[31];
            cfg[n]    = '{level_hi: pol_q[n], edge_mode: trig_q[n], both_edges: dual_q[n]};
        end
    end

    sic_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (irq_in),
        .smp_o (smp)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        sic_line u_line (
            .clk      (clk),
            .rst      (rst),
            .smp_i    (smp[n]),
            .cfg_i    (cfg[n]),
            .sw_set_i (sw_set[n]),
            .sw_clr_i (sw_clr[n]),
            .pend_o   (pend[n])
        );
    end

    assign act = pend & mask_q;

    sic_router #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) u_router (
        .act_i   (act),
        .route_i (route_q),
        .pin_o   (irq_pin),
        .nmi_o   (irq_nmi)
    );

    // read path
    always_comb begin
        rd_word = '0;
        case (sel)
            RG_POL:  rd_word = pick_word(pol_q, wsel);
            RG_TRIG: rd_word = pick_word(trig_q, wsel);
            RG_DUAL: rd_word = pick_word(dual_q, wsel);
            RG_MASK: rd_word = pick_word(mask_q, wsel);
            RG_PEND: rd_word = pick_word(pend, wsel);
            RG_MAP: begin
                for (int n = 0; n < NUM_LINES; n++)
                    if (midx == MIDX_W'(n)) rd_word = route_word(route_q[n]);
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_re) rdata_q <= rd_word;
    end

    assign reg_rdata = rdata_q;

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == RG_MSET && wsel == 5'd0)
        |=> ((mask_q[REG_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == RG_MCLR && wsel == 5'd0)
        |=> ((mask_q[REG_W-1:0] & $past(reg_wdata)) == '0));

    // R8
    map_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == RG_MAP && midx == '0)
        |=> (route_word(route_q[0]) == ($past(reg_wdata) & 32'hC000_003F)));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata));

    // R9 R10
    quiet_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (irq_pin == '0 && !irq_nmi));
endmodule

// File: tb/test_shared_irq_cond.sv
`timescale 1ns/1ps
module test_shared_irq_cond;
    localparam int NL = 64;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] irq_in;
    logic          reg_we, reg_re;
    logic [11:0]   reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic [NP-1:0] irq_pin;
    logic          irq_nmi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NL-1:0] m_pol, m_trig, m_dual, m_mask, m_in, m_pend;
    logic          m_topin [NL];
    logic          m_tonmi [NL];
    int            m_pin   [NL];

    always #2.5 clk = ~clk;

    shared_irq_cond #(.NUM_LINES(NL), .NUM_PINS(NP)) i_shared_irq_cond (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pin(irq_pin), .irq_nmi(irq_nmi)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [NP-1:0] exp_pins();
        logic [NP-1:0] r = '0;
        for (int n = 0; n < NL; n++)
            if (m_pend[n] && m_mask[n] && m_topin[n] && m_pin[n] < NP) r[m_pin[n]] = 1'b1;
        return r;
    endfunction

    function automatic logic exp_nmi();
        logic r = 1'b0;
        for (int n = 0; n < NL; n++)
            if (m_pend[n] && m_mask[n] && m_tonmi[n]) r = 1'b1;
        return r;
    endfunction

    function automatic void refresh_level();
        logic [NL-1:0] lvl = ~(m_pol ^ m_in);
        m_pend = (m_pend & m_trig) | (lvl & ~m_trig);
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] w;
        reg_read(12'h480, w); chk(tag, "pending word0", w, m_pend[31:0]);
        reg_read(12'h484, w); chk(tag, "pending word1", w, m_pend[63:32]);
        chk(tag, "pins", {24'b0, irq_pin}, {24'b0, exp_pins()});
        chk(tag, "nmi", {31'b0, irq_nmi}, {31'b0, exp_nmi()});
    endtask

    task automatic apply_input(input int n, input logic v);
        logic old = m_in[n];
        @(negedge clk);
        irq_in[n] = v;
        m_in[n] = v;
        repeat (4) @(negedge clk);
        if (m_trig[n] && old != v && (m_dual[n] || m_pol[n] == v)) m_pend[n] = 1'b1;
        refresh_level();
    endtask

    task automatic sw_edge(input int n, input logic set);
        reg_write(12'h280, {set, 23'b0, 8'(n)});
        if (n < NL && m_trig[n]) m_pend[n] = set;
    endtask

    task automatic set_map(input int n, input logic tp, input logic tn, input int p);
        reg_write(12'h500 + 12'(4 * n), {tp, tn, 24'b0, 6'(p)});
        m_topin[n] = tp; m_tonmi[n] = tn; m_pin[n] = p;
    endtask

    task automatic push_cfg();
        for (int w = 0; w < 2; w++) begin
            reg_write(12'h100 + 12'(4 * w), m_pol[w*32 +: 32]);
            reg_write(12'h180 + 12'(4 * w), m_trig[w*32 +: 32]);
            reg_write(12'h200 + 12'(4 * w), m_dual[w*32 +: 32]);
            reg_write(12'h300 + 12'(4 * w), ~m_mask[w*32 +: 32]);
            reg_write(12'h380 + 12'(4 * w), m_mask[w*32 +: 32]);
        end
        for (int n = 0; n < NL; n++) sw_edge(n, 1'b0);
        refresh_level();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; irq_in = '0; reg_we = 1'b0; reg_re = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        m_pol = '1; m_trig = '0; m_dual = '0; m_mask = '0; m_in = '0; m_pend = '0;
        for (int n = 0; n < NL; n++) begin m_topin[n] = 0; m_tonmi[n] = 0; m_pin[n] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(12'h400, d); chk("R1", "mask word0", d, 32'h0);
        reg_read(12'h480, d); chk("R1", "pending word0", d, 32'h0);
        reg_read(12'h500, d); chk("R1", "map line0", d, 32'h0);
        reg_read(12'h104, d); chk("R1", "polarity word1", d, 32'hFFFF_FFFF);
        reg_read(12'h180, d); chk("R1", "trigger word0", d, 32'h0);
        chk("R1", "outputs", {23'b0, irq_nmi, irq_pin}, 32'h0);

        // directed configuration
        m_pol[3] = 0; m_pol[5] = 0; m_pol[6] = 0;
        m_trig[7:4] = 4'hF; m_dual[6] = 1'b1;
        m_mask[7:2] = 6'h3F;
        set_map(2, 1, 0, 1); set_map(3, 1, 0, 2); set_map(4, 1, 0, 3);
        set_map(5, 0, 1, 0); set_map(6, 1, 1, 9); set_map(7, 1, 0, 0);
        push_cfg();
        check_all("R2 active-low idle");
        reg_read(12'h180, d); chk("R7", "trigger word0", d, 32'h0000_00F0);
        reg_read(12'h100, d); chk("R7", "polarity word0", d, 32'hFFFF_FF97);

        apply_input(2, 1); check_all("R2 active-high");
        apply_input(3, 1); check_all("R2 active-low released");
        apply_input(4, 1); check_all("R3 rising");
        apply_input(4, 0); check_all("R3 sticky");
        sw_edge(4, 0);     check_all("R5 clear");
        apply_input(5, 1); check_all("R3 falling-only ignores rise");
        apply_input(5, 0); check_all("R3 R10 falling to nmi");
        apply_input(6, 1); check_all("R4 rise with pol0");
        sw_edge(6, 0);
        apply_input(6, 0); check_all("R4 fall, R9 pin out of range");
        sw_edge(2, 0);     check_all("R5 level line ignores clear");
        sw_edge(200, 1);   check_all("R5 absent line ignored");
        sw_edge(7, 1);     check_all("R5 set pin0");

        reg_write(12'h380, 32'h0);
        reg_write(12'h300, 32'h0);
        reg_read(12'h400, d); chk("R6", "mask after zero writes", d, m_mask[31:0]);
        reg_write(12'h300, 32'h0000_0080); m_mask[7] = 1'b0;
        reg_read(12'h400, d); chk("R6", "mask after clear bit7", d, m_mask[31:0]);
        check_all("R6 masked line7");
        reg_read(12'h508, d); chk("R8", "map line2", d, 32'h8000_0001);
        reg_read(12'h518, d); chk("R8", "map line6", d, 32'hC000_0009);
        reg_read(12'h004, d); chk("R11", "unmapped address", d, 32'h0);
        @(negedge clk); reg_addr = 12'h100;
        @(negedge clk); chk("R11", "read data holds", reg_rdata, 32'h0);

        // constrained random rounds
        for (int round = 0; round < 3; round++) begin
            m_pol  = {$urandom, $urandom};
            m_trig = {$urandom, $urandom};
            m_dual = {$urandom, $urandom};
            m_mask = {$urandom, $urandom};
            for (int n = 0; n < NL; n++)
                set_map(n, ($urandom % 4) != 0, ($urandom % 6) == 0, $urandom % 10);
            push_cfg();
            check_all("R7 R9 random config");
            for (int it = 0; it < 40; it++) begin
                int n = $urandom % NL;
                if (($urandom % 4) == 3) sw_edge(n, 1'($urandom));
                else apply_input(n, ~m_in[n]);
                check_all("R9 R10 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule